// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of a digital signal by counting its rising edges over a fixed gate window. The window is timed in ticks of a slow reference clock. The signal to be counted is expected to be a clean, already-synchronised digital level. Its expected rate is roughly 0.4 to 12 MHz, which is below the system clock rate.

Software first writes a configuration word, which holds a 2-bit mode code and a 2-bit gate code. It then issues a start pulse. With a 75-tick-per-millisecond reference, the four gate codes give windows of 1, 4, 8 or 32 ms.

When the window closes, the count freezes and a completion flag rises. A read acknowledge clears the flag. If any of the halt, backup or PLL-stop conditions is present, the input is disabled and any measurement in progress is abandoned.

The controller has three states: `ST_IDLE` (waiting, last result held), `ST_COUNT` (window open, edges counted) and `ST_DONE` (window closed, flag raised). The transitions are as follows:
- START (`ST_IDLE` or `ST_DONE` to `ST_COUNT`) on an accepted start.
- CLOSE (`ST_COUNT` to `ST_DONE`) on the last reference tick of the window.
- ACK (`ST_DONE` to `ST_IDLE`) on a read acknowledge.
- ABORT (any state to `ST_IDLE`) while an inhibit input is high.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `count` is 0 and `done`, `ovf` and `busy` are all low.
- R2: Gate code 00, 01, 10 and 11 gives a window of 1, 4, 8 and 32 times `TICKS_PER_MS` reference ticks. The ticks are counted from the clock edge after the start edge. `done` stays low during the window and is high after the clock edge that samples the last tick. `busy` is high only while the window is open.
- R3: At the close, `count` equals the number of clock edges from the one after the start edge through the closing edge at which `sig_in` is 1 and was 0 at the previous edge.
- R4: A start is accepted only when the latched mode code is 00. With any other mode code, a start changes nothing: `busy`, `done` and `count` keep their values.
- R5: An accepted start clears `count`, `done` and `ovf` and opens a new window. A start while the window is open is ignored, and the running measurement completes unchanged.
- R6: `count` stops at all ones instead of wrapping. `ovf` is set when a rising edge arrives while `count` is all ones, and is otherwise 0 after a start.
- R7: `rd_ack` while `done` is high clears `done` on the next clock. `count` and `ovf` keep their values.
- R8: While any of `halt_req`, `backup_req` or `pll_stop` is high at a clock edge, the following cycle shows `busy`, `done` and `ovf` low and `count` 0. Starts and input edges have no effect while an inhibit is high.
- R9: `cfg_we` latches `cfg_mode` and `cfg_gate`. Both reset to 00, so a start issued before any configuration write measures with the 1 ms window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| sig_in | input | 1 | Synchronised signal whose rising edges are counted |
| cfg_we | input | 1 | Latch mode and gate codes |
| cfg_mode | input | 2 | Mode code; 00 selects frequency measurement |
| cfg_gate | input | 2 | Gate code (00=1, 01=4, 10=8, 11=32 ms) |
| start | input | 1 | Start a measurement |
| rd_ack | input | 1 | Result read; clears the completion flag |
| halt_req | input | 1 | Halt condition; inhibits and aborts |
| backup_req | input | 1 | Backup condition; inhibits and aborts |
| pll_stop | input | 1 | PLL-stop condition; inhibits and aborts |
| count | output | CNT_W | Edge count, frozen at window close |
| done | output | 1 | Completion flag |
| ovf | output | 1 | Count saturated during the window |
| busy | output | 1 | Window open |

## Verification
The assertions take three things for granted about the inputs:
- `sig_in` is already synchronous to `clk`.
- `ref_tick` is a single-cycle pulse.
- Inhibit inputs are plain levels, sampled each edge.

The bench drives every input on the falling clock edge and never pulses `ref_tick` on two consecutive cycles. It toggles `sig_in` no faster than once per clock, so each rising edge lasts at least one clock and the edge count in the checks is exact. Start and acknowledge are single-cycle pulses. A start during an open window is applied deliberately, to exercise the rule that it is ignored.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } ufc_state_e;

    localparam logic [1:0] MODE_FREQ = 2'b00;

    // Gate length in milliseconds for each gate code
    function automatic int unsigned gate_mult(input logic [1:0] sel);
        unique case (sel)
            2'b00:   gate_mult = 1;
            2'b01:   gate_mult = 4;
            2'b10:   gate_mult = 8;
            default: gate_mult = 32;
        endcase
    endfunction

endpackage

// File: rtl/ufc_gate_timer.sv
module ufc_gate_timer #(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    input  logic             ref_tick,
    output logic             expire
);
    logic [TMR_W-1:0] tmr_q;

    // Last tick of the window arrives while the timer reads one
    assign expire = run && ref_tick && (tmr_q == TMR_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (load) begin
            tmr_q <= load_val;
        end else if (run && ref_tick) begin
            tmr_q <= tmr_q - TMR_W'(1);
        end
    end
endmodule

// File: rtl/ufc_edge_counter.sv
module ufc_edge_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             sig_in,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             sig_d;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign rise  = sig_in && !sig_d;
    assign count = cnt_q;
    assign ovf   = ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_d <= 1'b0;
        end else begin
            sig_d <= sig_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (en && rise) begin
            if (cnt_q == CNT_MAX) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import ufc_pkg::*;
#(
    parameter int CNT_W        = 20,
    parameter int TICKS_PER_MS = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             sig_in,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_gate,
    input  logic             start,
    input  logic             rd_ack,
    input  logic             halt_req,
    input  logic             backup_req,
    input  logic             pll_stop,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             ovf,
    output logic             busy
);
    localparam int TMR_W = $clog2(32 * TICKS_PER_MS + 1);

    ufc_state_e       state_q, state_d;
    logic [1:0]       mode_q, gate_q;
    logic             inhibit;
    logic             start_ok;
    logic             launch;
    logic             expire;
    logic [TMR_W-1:0] load_val;

    assign inhibit  = halt_req || backup_req || pll_stop;
    assign start_ok = start && (mode_q == MODE_FREQ) && !inhibit;
    assign launch   = start_ok && (state_q != ST_COUNT);
    assign load_val = TMR_W'(TICKS_PER_MS * gate_mult(gate_q));

    // Configuration word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FREQ;
            gate_q <= 2'b00;
        end else if (cfg_we) begin
            mode_q <= cfg_mode;
            gate_q <= cfg_gate;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (inhibit) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_ok) state_d = ST_COUNT;
                ST_COUNT: if (expire)   state_d = ST_DONE;
                ST_DONE: begin
                    if (start_ok)    state_d = ST_COUNT;
                    else if (rd_ack) state_d = ST_IDLE;
                end
                default:             state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_COUNT: busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    ufc_gate_timer #(
        .TMR_W(TMR_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (load_val),
        .run      (state_q == ST_COUNT),
        .ref_tick (ref_tick),
        .expire   (expire)
    );

    ufc_edge_counter #(
        .CNT_W(CNT_W)
    ) counter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (launch || inhibit),
        .en     (state_q == ST_COUNT),
        .sig_in (sig_in),
        .count  (count),
        .ovf    (ovf)
    );
endmodule

// File: rtl/ufc_chk.sv
module ufc_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_ack,
    input logic             halt_req,
    input logic             backup_req,
    input logic             pll_stop,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             ovf,
    input logic             busy
);
    logic inh;
    assign inh = halt_req || backup_req || pll_stop;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !done && !ovf && !busy)); // R1

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R2

    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R2

    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inh) |=> (count >= $past(count))); // R3

    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == {CNT_W{1'b1}})); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !inh) |=> ($stable(count) && $stable(ovf))); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_ack && !inh) |=> !done); // R7

    AST_INHIBIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        inh |=> (!busy && !done && !ovf && count == '0)); // R8
endmodule

bind freq_gate_counter ufc_chk #(
    .CNT_W(CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_ack     (rd_ack),
    .halt_req   (halt_req),
    .backup_req (backup_req),
    .pll_stop   (pll_stop),
    .count      (count),
    .done       (done),
    .ovf        (ovf),
    .busy       (busy)
);

// File: tb/freq_gate_counter_tb_top.sv
module freq_gate_counter_tb_top;
    localparam int CW   = 10;
    localparam int TPM  = 75;
    localparam int MAXV = (1 << CW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          sig_in = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [1:0]    cfg_gate = 2'b00;
    logic          start = 1'b0;
    logic          rd_ack = 1'b0;
    logic          halt_req = 1'b0;
    logic          backup_req = 1'b0;
    logic          pll_stop = 1'b0;
    logic [CW-1:0] count;
    logic          done;
    logic          ovf;
    logic          busy;

    int            n_chk = 0;
    int            n_bad = 0;
    exp_t          exp_q[$];
    logic [CW-1:0] last_cnt = '0;
    logic          done_q = 1'b0;

    always #10 clk = ~clk;

    freq_gate_counter #(
        .CNT_W        (CW),
        .TICKS_PER_MS (TPM)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .sig_in     (sig_in),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_gate   (cfg_gate),
        .start      (start),
        .rd_ack     (rd_ack),
        .halt_req   (halt_req),
        .backup_req (backup_req),
        .pll_stop   (pll_stop),
        .count      (count),
        .done       (done),
        .ovf        (ovf),
        .busy       (busy)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int mult(input logic [1:0] g);
        case (g)
            2'b00:   mult = 1;
            2'b01:   mult = 4;
            2'b10:   mult = 8;
            default: mult = 32;
        endcase
    endfunction

    task automatic cfg(input logic [1:0] m, input logic [1:0] g);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_gate = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_free(input int cycles, input int half);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            sig_in   = ((k % (2 * half)) >= half);
            ref_tick = (k % 2 == 1);
        end
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    // Driver: runs one window, pushes the expected result to the scoreboard
    task automatic measure(input logic [1:0] gate, input int half, input int poke,
                           input string req);
        int   len, n, ticks, edges;
        logic prev, s, bad;
        exp_t e;
        len = TPM * mult(gate);
        @(negedge clk);
        start = 1'b1; sig_in = 1'b0; ref_tick = 1'b0;
        prev = 1'b0; n = 0; ticks = 0; edges = 0; bad = 1'b0;
        while (ticks < len) begin
            @(negedge clk);
            if (done || !busy) bad = 1'b1;
            start    = (poke > 0 && n == poke);
            s        = ((n % (2 * half)) >= half);
            sig_in   = s;
            ref_tick = (n % 2 == 1);
            if (s && !prev) edges++;
            prev = s;
            if (ref_tick) ticks++;
            n++;
        end
        e.cnt = (edges > MAXV) ? CW'(MAXV) : CW'(edges);
        e.ovf = (edges > MAXV);
        exp_q.push_back(e);
        last_cnt = e.cnt;
        chk(!bad, req, "busy high and done low through window", bad, 0);
        @(negedge clk);
        start = 1'b0; ref_tick = 1'b0;
        chk(done == 1'b1, "R2", "done after closing tick", done, 1);
        chk(busy == 1'b0, "R2", "busy after closing tick", busy, 0);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        chk(done == 1'b0, "R7", "done after rd_ack", done, 0);
        chk(count == last_cnt, "R7", "count held after rd_ack", count, last_cnt);
    endtask

    // Monitor: compares each completed result against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done && !done_q) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(count == e.cnt, "R3", "edge count at close", count, e.cnt);
                chk(ovf == e.ovf, "R6", "overflow flag at close", ovf, e.ovf);
            end
        end
        done_q = done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(count == '0, "R1", "count in reset", count, 0);
        chk(!done, "R1", "done in reset", done, 0);
        chk(!ovf, "R1", "ovf in reset", ovf, 0);
        chk(!busy, "R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        measure(2'b00, 2, 0, "R9");           // default config: 1 ms
        cfg(2'b00, 2'b01);
        measure(2'b01, 3, 30, "R5");          // start mid-window ignored
        cfg(2'b00, 2'b10);
        measure(2'b10, 5, 0, "R2");
        cfg(2'b00, 2'b11);
        measure(2'b11, 1, 0, "R6");           // saturates
        cfg(2'b00, 2'b00);
        measure(2'b00, 2, 0, "R5");           // new start clears ovf

        // R4: non-zero mode code blocks start
        cfg(2'b01, 2'b00);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        run_free(200, 1);
        chk(!busy, "R4", "busy with mode 01", busy, 0);
        chk(!done, "R4", "done with mode 01", done, 0);
        chk(count == last_cnt, "R4", "count with mode 01", count, last_cnt);
        cfg(2'b00, 2'b00);

        // R8: each inhibit aborts and blocks
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            run_free(40, 2);
            chk(busy && count != '0, "R8", "window running before inhibit", count, 10);
            @(negedge clk);
            halt_req = (i == 0); backup_req = (i == 1); pll_stop = (i == 2);
            @(negedge clk);
            chk(!busy && !done && !ovf, "R8", "flags after inhibit", {busy, done, ovf}, 0);
            chk(count == '0, "R8", "count after inhibit", count, 0);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            run_free(20, 1);
            chk(!busy && count == '0, "R8", "start and edges under inhibit", count, 0);
            @(negedge clk);
            halt_req = 1'b0; backup_req = 1'b0; pll_stop = 1'b0;
            run_free(10, 1);
        end

        measure(2'b00, 4, 0, "R8");           // normal after inhibit
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule